// File: doc/BRIEF.md
# Stream Packet Keep-Rule Monitor

This block watches one AXI4-Stream link that carries data, byte-keep and end-of-packet signals. It never drives the link. It reports any transfer that breaks the packet rules used on kernel streams. The byte-keep rule is strict. Every beat except the last must keep all bytes. The last beat must keep a run of low-order bytes with no gaps. No beat may keep zero bytes.

The monitor also checks two other things. First, the kernel must not take or offer data before it has been started. Second, a beat that has been offered must stay unchanged until it is accepted.

Besides the error flags, the block counts completed packets and reports the byte length of the most recent packet. Each error flag stays set until a synchronous clear.

A parameter selects which side of the link belongs to the kernel. On the receiving side, the ready signal is the one policed before start. On the sending side, the valid signal is policed. The data width is also a parameter. Any width other than 8, 16, 32, 64, 128, 256 or 512 bits stops elaboration.

Top module: `axis_keep_monitor`

## Requirements
- R1: A beat counts as transferred only in a cycle where `tvalid` and `tready` are both high. In any other cycle, `pkt_count` and `last_len` keep their values and no keep error is raised, whatever `tkeep`, `tlast` and `tdata` carry.
- R2: On a transfer with `tlast` low, `err_mid_keep` is set one clock later if `tkeep` is neither all ones nor all zeros.
- R3: On a transfer with `tlast` high, `err_tail_keep` is set one clock later if `tkeep` is non-zero and is not of the form 2^n-1. On a 4-byte bus the legal values are 0001, 0011, 0111 and 1111.
- R4: On any transfer, final or not, `err_zero_keep` is set one clock later if `tkeep` is all zeros.
- R5: While `started` is low, `err_early` is set one clock later if the policed signal is high. With `SLAVE_SIDE`=1 the policed signal is `tready`; with `SLAVE_SIDE`=0 it is `tvalid`.
- R6: After a cycle with `tvalid` high and `tready` low, `err_unstable` is set one clock later if, in the next cycle, `tvalid` is low or any of `tdata`, `tkeep` or `tlast` differs.
- R7: Each transfer with `tlast` high adds one to `pkt_count`, visible one clock later.
- R8: On a transfer with `tlast` high, `last_len` becomes the number of earlier beats in the packet times the bus byte count, plus the number of ones in the final `tkeep`. This value is visible one clock later. The next packet then starts its beat count from zero.
- R9: Error flags are sticky. `clr` high clears all five flags at the next edge, and it takes priority over a violation in the same cycle.
- R10: While `rst_n` is low, all flags, `pkt_count`, `last_len` and the held-beat state are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of the error flags |
| started | input | 1 | High once the kernel has been started |
| tvalid | input | 1 | Stream valid |
| tready | input | 1 | Stream ready |
| tdata | input | DATA_W | Stream data |
| tkeep | input | DATA_W/8 | Stream byte keep |
| tlast | input | 1 | End of packet |
| err_mid_keep | output | 1 | Non-final beat with partial keep |
| err_tail_keep | output | 1 | Final beat with gapped or high-order keep |
| err_zero_keep | output | 1 | Beat with no byte kept |
| err_early | output | 1 | Link activity before start |
| err_unstable | output | 1 | Offered beat changed or withdrawn |
| pkt_count | output | PKT_W | Completed packets |
| last_len | output | BEAT_W+log2(DATA_W/8)+1 | Byte length of the latest packet |

## Verification
A wrong beat counter does not show at once. It shows only at the next end-of-packet beat, as a `last_len` off by a multiple of the bus byte count, so the bench runs packets of many lengths.

A wrong held-beat register shows as a spurious or missing `err_unstable` in the cycle right after a stall.

A flag that fails to stick, or that ignores the clear, is hidden while the link stays clean. For that reason the bench issues clears at random times and compares every flag in every cycle against its own model.

// File: rtl/axis_keep_monitor.sv
module axis_keep_monitor #(
  parameter int DATA_W     = 32,
  parameter int BEAT_W     = 12,
  parameter int PKT_W      = 16,
  parameter bit SLAVE_SIDE = 1'b1,
  localparam int BYTES     = DATA_W / 8,
  localparam int LEN_W     = BEAT_W + $clog2(BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              started,
  input  logic              tvalid,
  input  logic              tready,
  input  logic [DATA_W-1:0] tdata,
  input  logic [BYTES-1:0]  tkeep,
  input  logic              tlast,
  output logic              err_mid_keep,
  output logic              err_tail_keep,
  output logic              err_zero_keep,
  output logic              err_early,
  output logic              err_unstable,
  output logic [PKT_W-1:0]  pkt_count,
  output logic [LEN_W-1:0]  last_len
);

  if (!(DATA_W == 8 || DATA_W == 16 || DATA_W == 32 || DATA_W == 64 ||
        DATA_W == 128 || DATA_W == 256 || DATA_W == 512)) begin : g_bad_width
    $error("axis_keep_monitor: DATA_W must be a power of two from 8 to 512");
  end

  logic              fire;
  logic              keep_full, keep_none, keep_run;
  logic [BYTES-1:0]  keep_inc;
  logic              mid_bad, tail_bad, zero_bad, early_bad, unstable_bad;
  logic              hold_q;
  logic [DATA_W-1:0] data_q;
  logic [BYTES-1:0]  keep_q;
  logic              last_q;
  logic [BEAT_W-1:0] beats_q;

  assign fire      = tvalid & tready;
  assign keep_full = &tkeep;
  assign keep_none = ~|tkeep;
  assign keep_inc  = tkeep + 1'b1;
  assign keep_run  = ~|(keep_inc & tkeep);

  assign mid_bad      = fire & ~tlast & ~keep_full & ~keep_none;
  assign tail_bad     = fire & tlast & ~keep_none & ~keep_run;
  assign zero_bad     = fire & keep_none;
  assign early_bad    = ~started & (SLAVE_SIDE ? tready : tvalid);
  assign unstable_bad = hold_q & (~tvalid | (tdata != data_q) |
                                  (tkeep != keep_q) | (tlast != last_q));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      err_mid_keep  <= 1'b0;
      err_tail_keep <= 1'b0;
      err_zero_keep <= 1'b0;
      err_early     <= 1'b0;
      err_unstable  <= 1'b0;
    end else begin
      err_mid_keep  <= err_mid_keep  | mid_bad;
      err_tail_keep <= err_tail_keep | tail_bad;
      err_zero_keep <= err_zero_keep | zero_bad;
      err_early     <= err_early     | early_bad;
      err_unstable  <= err_unstable  | unstable_bad;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      data_q <= '0;
      keep_q <= '0;
      last_q <= 1'b0;
    end else begin
      hold_q <= tvalid & ~tready;
      data_q <= tdata;
      keep_q <= tkeep;
      last_q <= tlast;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beats_q   <= '0;
      pkt_count <= '0;
      last_len  <= '0;
    end else if (fire) begin
      if (tlast) begin
        beats_q   <= '0;
        pkt_count <= pkt_count + 1'b1;
        last_len  <= LEN_W'(beats_q) * LEN_W'(BYTES) + LEN_W'($countones(tkeep));
      end else begin
        beats_q <= beats_q + 1'b1;
      end
    end
  end

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(pkt_count) && $stable(last_len));
  // R2
  mid_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !tlast && !keep_full && !keep_none && !clr |=> err_mid_keep);
  // R3
  tail_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && tlast && !keep_none && !keep_run && !clr |=> err_tail_keep);
  // R4
  zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && keep_none && !clr |=> err_zero_keep);
  // R5
  early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !started && (SLAVE_SIDE ? tready : tvalid) && !clr |=> err_early);
  // R7
  pkt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && tlast |=> pkt_count == $past(pkt_count) + 1'b1);
  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !err_mid_keep && !err_tail_keep && !err_zero_keep && !err_early && !err_unstable);
  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && err_unstable |=> err_unstable);

endmodule

// File: tb/axis_keep_monitor_bench.sv
module axis_keep_monitor_bench;
  localparam int DATA_W = 32;
  localparam int BYTES  = DATA_W / 8;
  localparam int LEN_W  = 12 + 2 + 1;

  logic clk = 1'b0;
  logic rst_n, clr, started, tvalid, tready, tlast;
  logic [DATA_W-1:0] tdata;
  logic [BYTES-1:0]  tkeep;
  logic err_mid_keep, err_tail_keep, err_zero_keep, err_early, err_unstable;
  logic [15:0] pkt_count;
  logic [LEN_W-1:0] last_len;

  int vectors = 0;
  int miscompares = 0;

  logic m_mid, m_tail, m_zero, m_early, m_unst, m_hold, m_last;
  logic [DATA_W-1:0] m_data;
  logic [BYTES-1:0] m_keep;
  int m_beats, m_pkts, m_len;

  always #4 clk = ~clk;

  axis_keep_monitor u_axis_keep_monitor (
    .clk(clk), .rst_n(rst_n), .clr(clr), .started(started),
    .tvalid(tvalid), .tready(tready), .tdata(tdata), .tkeep(tkeep), .tlast(tlast),
    .err_mid_keep(err_mid_keep), .err_tail_keep(err_tail_keep),
    .err_zero_keep(err_zero_keep), .err_early(err_early),
    .err_unstable(err_unstable), .pkt_count(pkt_count), .last_len(last_len));

  function automatic bit tail_legal(logic [BYTES-1:0] k);
    for (int i = 1; i <= BYTES; i++)
      if (int'(k) == (1 << i) - 1) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int ones(logic [BYTES-1:0] k);
    int n = 0;
    for (int i = 0; i < BYTES; i++) n += int'(k[i]);
    return n;
  endfunction

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_mid = 0; m_tail = 0; m_zero = 0; m_early = 0; m_unst = 0;
    m_hold = 0; m_last = 0; m_data = '0; m_keep = '0;
    m_beats = 0; m_pkts = 0; m_len = 0;
  endtask

  task automatic model_step();
    bit f;
    bit bm, bt, bz, be, bu;
    f  = tvalid && tready;
    bm = f && !tlast && tkeep != {BYTES{1'b1}} && tkeep != '0;
    bt = f && tlast && tkeep != '0 && !tail_legal(tkeep);
    bz = f && tkeep == '0;
    be = !started && tready;
    bu = m_hold && (!tvalid || tdata != m_data || tkeep != m_keep || tlast != m_last);
    if (clr) begin
      m_mid = 0; m_tail = 0; m_zero = 0; m_early = 0; m_unst = 0;
    end else begin
      m_mid |= bm; m_tail |= bt; m_zero |= bz; m_early |= be; m_unst |= bu;
    end
    m_hold = tvalid && !tready;
    m_data = tdata; m_keep = tkeep; m_last = tlast;
    if (f) begin
      if (tlast) begin
        m_len = m_beats * BYTES + ones(tkeep);
        m_pkts = (m_pkts + 1) & 16'hFFFF;
        m_beats = 0;
      end else m_beats++;
    end
  endtask

  task automatic compare_all();
    chk("R2 err_mid_keep", int'(err_mid_keep), int'(m_mid));
    chk("R3 err_tail_keep", int'(err_tail_keep), int'(m_tail));
    chk("R4 err_zero_keep", int'(err_zero_keep), int'(m_zero));
    chk("R5 err_early", int'(err_early), int'(m_early));
    chk("R6 err_unstable", int'(err_unstable), int'(m_unst));
    chk("R7 pkt_count", int'(pkt_count), m_pkts);
    chk("R8 last_len", int'(last_len), m_len);
  endtask

  task automatic cyc(bit c, bit s, bit v, bit r, logic [DATA_W-1:0] d,
                     logic [BYTES-1:0] k, bit l);
    clr = c; started = s; tvalid = v; tready = r; tdata = d; tkeep = k; tlast = l;
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(8 * 150000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    rst_n = 0; clr = 0; started = 0; tvalid = 0; tready = 0;
    tdata = '0; tkeep = '0; tlast = 0;
    repeat (3) @(negedge clk);
    model_reset();
    // R10 reset state
    chk("R10 flags at reset", int'({err_mid_keep, err_tail_keep, err_zero_keep, err_early, err_unstable}), 0);
    chk("R10 pkt_count at reset", int'(pkt_count), 0);
    chk("R10 last_len at reset", int'(last_len), 0);
    rst_n = 1;

    // R8 lengths of several shapes
    cyc(0, 1, 1, 1, 32'h11, 4'hF, 0);
    cyc(0, 1, 1, 1, 32'h22, 4'hF, 0);
    cyc(0, 1, 1, 1, 32'h33, 4'h3, 1);
    chk("R8 len 3 beats tail 0011", int'(last_len), 10);
    cyc(0, 1, 1, 1, 32'h44, 4'h1, 1);
    chk("R8 len single tail 0001", int'(last_len), 1);
    cyc(0, 1, 1, 1, 32'h55, 4'hF, 0);
    cyc(0, 1, 1, 1, 32'h66, 4'h7, 1);
    chk("R8 len 2 beats tail 0111", int'(last_len), 7);
    chk("R7 three packets", int'(pkt_count), 3);

    // R1 no transfer without both handshakes
    cyc(0, 1, 0, 1, 32'h77, 4'h0, 1);
    cyc(0, 1, 1, 0, 32'h88, 4'h5, 1);
    chk("R1 pkt_count unchanged", int'(pkt_count), 3);
    chk("R1 no keep error", int'({err_mid_keep, err_tail_keep, err_zero_keep}), 0);
    cyc(0, 1, 0, 0, 32'h88, 4'h5, 1);
    cyc(1, 1, 0, 0, 32'h0, 4'h0, 0);

    // R2 partial keep mid-packet
    cyc(0, 1, 1, 1, 32'h1, 4'h7, 0);
    chk("R2 mid flag set", int'(err_mid_keep), 1);
    cyc(0, 1, 1, 1, 32'h2, 4'hF, 1);
    // R9 sticky over idle then cleared
    cyc(0, 1, 0, 0, 32'h0, 4'h0, 0);
    cyc(0, 1, 0, 0, 32'h0, 4'h0, 0);
    chk("R9 flag sticky", int'(err_mid_keep), 1);
    cyc(1, 1, 1, 1, 32'h3, 4'h0, 1);
    chk("R9 clear wins over violation", int'({err_mid_keep, err_zero_keep}), 0);

    // R3 gapped and high-order tails
    cyc(0, 1, 1, 1, 32'h4, 4'h5, 1);
    chk("R3 tail 0101 flagged", int'(err_tail_keep), 1);
    cyc(1, 1, 0, 0, 32'h0, 4'h0, 0);
    cyc(0, 1, 1, 1, 32'h4, 4'h8, 1);
    chk("R3 tail 1000 flagged", int'(err_tail_keep), 1);
    cyc(1, 1, 0, 0, 32'h0, 4'h0, 0);

    // R4 zero keep on final beat
    cyc(0, 1, 1, 1, 32'h5, 4'h0, 1);
    chk("R4 zero keep flagged", int'(err_zero_keep), 1);
    chk("R3 zero keep not a tail error", int'(err_tail_keep), 0);
    cyc(1, 1, 0, 0, 32'h0, 4'h0, 0);

    // R5 ready before start
    cyc(0, 0, 1, 0, 32'h0, 4'hF, 0);
    cyc(0, 0, 1, 1, 32'h0, 4'hF, 1);
    chk("R5 early flagged", int'(err_early), 1);
    cyc(1, 1, 0, 0, 32'h0, 4'h0, 0);

    // R6 beat changed during stall
    cyc(0, 1, 1, 0, 32'hAA, 4'hF, 0);
    cyc(0, 1, 1, 1, 32'hAB, 4'hF, 0);
    chk("R6 unstable flagged", int'(err_unstable), 1);
    cyc(1, 1, 1, 0, 32'hAC, 4'hF, 1);
    cyc(0, 1, 1, 1, 32'hAC, 4'hF, 1);
    chk("R6 held beat clean", int'(err_unstable), 0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit c, s, v, r, l;
      logic [DATA_W-1:0] d;
      logic [BYTES-1:0] k;
      c = ($urandom % 16) == 0;
      s = ($urandom % 32) != 0;
      if (m_hold && ($urandom % 16) != 0) begin
        v = 1; d = m_data; k = m_keep; l = m_last;
      end else begin
        v = ($urandom % 4) != 0;
        d = $urandom;
        l = ($urandom % 4) == 0;
        if (l) k = (($urandom % 8) != 0) ? BYTES'((1 << (1 + $urandom % BYTES)) - 1) : BYTES'($urandom);
        else   k = (($urandom % 16) != 0) ? {BYTES{1'b1}} : BYTES'($urandom);
      end
      r = s ? (($urandom % 3) != 0) : (($urandom % 8) == 0);
      cyc(c, s, v, r, d, k, l);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule